// File: doc/BRIEF.md
# Asynchronous Static Memory Phase Sequencer

This block produces the strobe timing for a single asynchronous read or write to an external parallel static memory. Supported parts are SRAM, PSRAM and NOR-style devices. A host raises a request carrying a direction flag, an address, write data and a bus-mode flag. The bus-mode flag chooses whether address and data share one bus (multiplexed) or use separate buses. Three timing fields come with the request: address setup, address hold and data phase. Each is counted in cycles of the clock that runs the block.

An access runs through a fixed sequence of phases:

1. An optional address setup phase.
2. An address hold phase, used only in multiplexed mode.
3. A data phase.
4. A return to idle.

Chip select, output enable, write enable, address-valid and the shared bus with its drive enable all follow from the current phase. The data phase ends with a one-cycle done pulse, and for reads this pulse comes with the sampled read data. A request is taken only while the block is idle. The timing fields are captured at that moment.

Top module: `sram_phase_seq`

## Requirements
- R1: After reset all strobes are inactive: chip select, output enable, write enable and address-valid are high. The shared-bus enable is low, the done pulse is low and the ready output is high.
- R2: The setup phase lasts exactly the setup field (4 bits, 0..15) cycles. Chip select is low, and output enable and write enable stay high. A value of 0 inserts no setup cycle.
- R3: The hold phase exists only when the multiplexed flag is 1. It lasts the hold field (4 bits, 1..15) cycles, and a hold code of 0 gives one cycle. In non-multiplexed mode there is no hold cycle, whatever the field holds.
- R4: The data phase lasts the data field (8 bits, 1..255) cycles, and a data code of 0 gives one cycle.
- R5: Read data phase and completion:
  - Output enable is low for every data-phase cycle.
  - Write enable stays high and the shared bus is not driven.
  - The bus value present in the last data cycle appears on the read-data output.
  - The done output is high for exactly the one cycle that follows the last data cycle.
  - Output enable and write enable are never low together.
- R6: For a write, write enable is low for every data-phase cycle, the shared-bus enable is high and the shared bus carries the write data.
- R7: In multiplexed mode:
  - Address-valid is low for every setup cycle.
  - The shared bus is driven with the address during the setup and hold cycles.

  In non-multiplexed mode, address-valid stays high and the bus is not driven before the data phase. In both modes, the address output carries the request address while chip select is low.
- R8: A request is accepted only when ready is high, and ready is high exactly when chip select is high. A request raised during an access is ignored: address and strobes are unchanged and no further access follows. Chip select is high for at least one cycle between two accesses.
- R9: The timing fields are captured when a request is accepted. A change to the timing inputs during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all phase lengths count its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when ready is high |
| req_ready_o | output | 1 | High while idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mux_i | input | 1 | 1 = multiplexed address/data bus |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | BUS_W | Write data |
| cfg_setup_i | input | 4 | Address setup length in cycles |
| cfg_hold_i | input | 4 | Address hold length in cycles (0 treated as 1) |
| cfg_data_i | input | 8 | Data phase length in cycles (0 treated as 1) |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_adv_n_o | output | 1 | Address valid, active low |
| mem_addr_o | output | ADDR_W | Address lines |
| mem_ad_o | output | BUS_W | Shared bus outgoing value |
| mem_ad_oe_o | output | 1 | Shared bus drive enable |
| mem_ad_i | input | BUS_W | Shared bus incoming value |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | BUS_W | Read data, valid with done |

## Verification
A wrong phase state or a wrong count appears at once at the strobes. Such a fault shows in one of three ways:
- A setup, hold or data window that is one cycle too long or too short.
- A hold window in non-multiplexed mode.
- Output enable and write enable swapped.

The bench therefore counts each window cycle by cycle from chip select, address-valid and the two enables, and compares each count with the programmed field, including the zero codes and the maximum values. A read sampled in the wrong cycle shows in the read data at the done pulse, because the bench changes the bus value on every data cycle. A request accepted while busy shows in the next cycle as a changed address or a second access after done.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int SETUP_W = 4;
  localparam int HOLD_W  = 4;
  localparam int DPH_W   = 8;
  localparam int CNT_W   = (DPH_W > SETUP_W) ? ((DPH_W > HOLD_W) ? DPH_W : HOLD_W)
                                             : ((SETUP_W > HOLD_W) ? SETUP_W : HOLD_W);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HOLD  = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [HOLD_W-1:0]  hold;
    logic [DPH_W-1:0]   data;
  } timing_t;

  // slowest timing after reset
  localparam timing_t TIMING_RST = '{setup: '1, hold: '1, data: '1};

  // reserved zero codes run as one cycle
  function automatic timing_t fix_reserved(timing_t t);
    timing_t r;
    r = t;
    if (t.hold == '0) r.hold = HOLD_W'(1);
    if (t.data == '0) r.data = DPH_W'(1);
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] span(logic [CNT_W-1:0] len);
    return len - CNT_W'(1);
  endfunction
endpackage

// File: rtl/sps_req_latch.sv
module sps_req_latch
  import sps_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              write_i,
  input  logic              mux_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  timing_t           timing_i,
  output logic              write_o,
  output logic              mux_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BUS_W-1:0]  wdata_o,
  output timing_t           timing_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o  <= 1'b0;
      mux_o    <= 1'b0;
      addr_o   <= '0;
      wdata_o  <= '0;
      timing_o <= TIMING_RST;
    end else if (load_i) begin
      write_o  <= write_i;
      mux_o    <= mux_i;
      addr_o   <= addr_i;
      wdata_o  <= wdata_i;
      timing_o <= timing_i;
    end
  end
endmodule

// File: rtl/sps_phase_fsm.sv
module sps_phase_fsm
  import sps_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    mux_i,
  input  timing_t timing_i,
  input  logic    mux_q_i,
  input  timing_t timing_q_i,
  output phase_e  phase_o,
  output logic    last_o,
  output logic    accept_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last     = (phase_q != PH_IDLE) && (cnt_q == '0);
  assign accept_o = (phase_q == PH_IDLE) && req_valid_i;
  assign phase_o  = phase_q;
  assign last_o   = last;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (phase_q != PH_IDLE && !last) cnt_d = cnt_q - CNT_W'(1);
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid_i) begin
          // first phase uses the fields being captured now
          if (timing_i.setup != '0) begin
            phase_d = PH_SETUP;
            cnt_d   = span(CNT_W'(timing_i.setup));
          end else if (mux_i) begin
            phase_d = PH_HOLD;
            cnt_d   = span(CNT_W'(timing_i.hold));
          end else begin
            phase_d = PH_DATA;
            cnt_d   = span(CNT_W'(timing_i.data));
          end
        end
      end
      PH_SETUP: begin
        if (last) begin
          if (mux_q_i) begin
            phase_d = PH_HOLD;
            cnt_d   = span(CNT_W'(timing_q_i.hold));
          end else begin
            phase_d = PH_DATA;
            cnt_d   = span(CNT_W'(timing_q_i.data));
          end
        end
      end
      PH_HOLD: begin
        if (last) begin
          phase_d = PH_DATA;
          cnt_d   = span(CNT_W'(timing_q_i.data));
        end
      end
      PH_DATA: begin
        if (last) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/sps_bus_drv.sv
module sps_bus_drv
  import sps_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              last_i,
  input  logic              write_i,
  input  logic              mux_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [BUS_W-1:0]  mem_ad_i,
  output logic              cs_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic              adv_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BUS_W-1:0]  ad_o,
  output logic              ad_oe_o,
  output logic              done_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic active, addr_ph, data_ph;

  assign active  = (phase_i != PH_IDLE);
  assign addr_ph = (phase_i == PH_SETUP) || (phase_i == PH_HOLD);
  assign data_ph = (phase_i == PH_DATA);

  assign cs_n_o  = !active;
  assign oe_n_o  = !(data_ph && !write_i);
  assign we_n_o  = !(data_ph && write_i);
  assign adv_n_o = !((phase_i == PH_SETUP) && mux_i);
  assign addr_o  = active ? addr_i : '0;

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    if (addr_ph && mux_i) begin
      ad_o    = BUS_W'(addr_i);
      ad_oe_o = 1'b1;
    end else if (data_ph && write_i) begin
      ad_o    = wdata_i;
      ad_oe_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= data_ph && last_i;
      if (data_ph && last_i && !write_i) rdata_o <= mem_ad_i;
    end
  end
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sps_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic               req_mux_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [BUS_W-1:0]   req_wdata_i,
  input  logic [SETUP_W-1:0] cfg_setup_i,
  input  logic [HOLD_W-1:0]  cfg_hold_i,
  input  logic [DPH_W-1:0]   cfg_data_i,
  output logic               mem_cs_n_o,
  output logic               mem_oe_n_o,
  output logic               mem_we_n_o,
  output logic               mem_adv_n_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [BUS_W-1:0]   mem_ad_o,
  output logic               mem_ad_oe_o,
  input  logic [BUS_W-1:0]   mem_ad_i,
  output logic               done_o,
  output logic [BUS_W-1:0]   rdata_o
);
  timing_t           timing_in, timing_q;
  logic              accept, last;
  logic              write_q, mux_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  wdata_q;
  phase_e            phase;

  assign timing_in   = fix_reserved('{setup: cfg_setup_i, hold: cfg_hold_i, data: cfg_data_i});
  assign req_ready_o = (phase == PH_IDLE);

  sps_req_latch #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .write_i  (req_write_i),
    .mux_i    (req_mux_i),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .timing_i (timing_in),
    .write_o  (write_q),
    .mux_o    (mux_q),
    .addr_o   (addr_q),
    .wdata_o  (wdata_q),
    .timing_o (timing_q)
  );

  sps_phase_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .mux_i      (req_mux_i),
    .timing_i   (timing_in),
    .mux_q_i    (mux_q),
    .timing_q_i (timing_q),
    .phase_o    (phase),
    .last_o     (last),
    .accept_o   (accept)
  );

  sps_bus_drv #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .last_i  (last),
    .write_i (write_q),
    .mux_i   (mux_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .mem_ad_i(mem_ad_i),
    .cs_n_o  (mem_cs_n_o),
    .oe_n_o  (mem_oe_n_o),
    .we_n_o  (mem_we_n_o),
    .adv_n_o (mem_adv_n_o),
    .addr_o  (mem_addr_o),
    .ad_o    (mem_ad_o),
    .ad_oe_o (mem_ad_oe_o),
    .done_o  (done_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/sps_checker.sv
module sps_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic mem_cs_n_o,
  input logic mem_oe_n_o,
  input logic mem_we_n_o,
  input logic mem_adv_n_o,
  input logic mem_ad_oe_o,
  input logic done_o
);
  AST_READY_IS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == mem_cs_n_o);  // R8
  AST_ACCESS_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_cs_n_o) |-> $past(req_valid_i && req_ready_o));  // R8
  AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_n_o && !mem_we_n_o));  // R5
  AST_STROBE_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_n_o || !mem_we_n_o || !mem_adv_n_o) |-> !mem_cs_n_o);  // R2
  AST_READ_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> !mem_ad_oe_o);  // R5
  AST_WRITE_BUS_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_ad_oe_o);  // R6
  AST_ADV_BUS_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_n_o |-> mem_ad_oe_o);  // R7
  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mem_cs_n_o && $past(!mem_cs_n_o)));  // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R5
endmodule

bind sram_phase_seq sps_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .mem_cs_n_o (mem_cs_n_o),
  .mem_oe_n_o (mem_oe_n_o),
  .mem_we_n_o (mem_we_n_o),
  .mem_adv_n_o(mem_adv_n_o),
  .mem_ad_oe_o(mem_ad_oe_o),
  .done_o     (done_o)
);

// File: tb/tb_sram_phase_seq.sv
module tb_sram_phase_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_mux = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0, req_wdata = '0, mem_ad_i = '0;
  logic [3:0]  cfg_setup = '0, cfg_hold = '0;
  logic [7:0]  cfg_data = '0;
  logic        cs_n, oe_n, we_n, adv_n, ad_oe, done;
  logic [15:0] mem_addr, ad_o, rdata;
  int n_checks = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_phase_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_mux_i(req_mux),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cfg_setup_i(cfg_setup), .cfg_hold_i(cfg_hold), .cfg_data_i(cfg_data),
    .mem_cs_n_o(cs_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_adv_n_o(adv_n),
    .mem_addr_o(mem_addr), .mem_ad_o(ad_o), .mem_ad_oe_o(ad_oe), .mem_ad_i(mem_ad_i),
    .done_o(done), .rdata_o(rdata)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // One access; counts each window and checks bus contents cycle by cycle.
  task automatic run_access(input string name, input logic wr, input logic mux,
                            input logic [15:0] addr, input logic [15:0] wd,
                            input int s, input int h, input int d,
                            input logic [15:0] rbase, input bit poke, input int new_setup);
    int n_adv = 0, n_pre = 0, n_dat = 0, k = 0, act = 0, guard = 0;
    int bad_bus = 0, exp_h, exp_d, stray = 0;
    @(negedge clk);
    cfg_setup = 4'(s); cfg_hold = 4'(h); cfg_data = 8'(d);
    req_write = wr; req_mux = mux; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && guard < 600) begin
      if (!cs_n) begin
        if (mem_addr != addr) bad_bus++;
        if (!adv_n) n_adv++;
        if (oe_n && we_n) begin
          n_pre++;
          if (mux && (!ad_oe || ad_o != addr)) bad_bus++;
          if (!mux && ad_oe) bad_bus++;
        end else begin
          n_dat++;
          if (wr) begin
            if (we_n || !oe_n || !ad_oe || ad_o != wd) bad_bus++;
          end else begin
            if (!we_n || oe_n || ad_oe) bad_bus++;
            mem_ad_i = rbase + 16'(k);
            k++;
          end
        end
        // busy-time request and timing change (R8, R9)
        if (poke && act == 1) begin
          req_valid = 1'b1; req_addr = ~addr; req_write = ~wr;
          if (new_setup >= 0) cfg_setup = 4'(new_setup);
        end else if (poke && act == 2) begin
          req_valid = 1'b0; req_addr = addr; req_write = wr;
        end
        act++;
      end
      @(negedge clk);
      guard++;
    end
    check_eq("R8", {name, " finished before watchdog"}, int'(guard < 600), 1);
    exp_h = mux ? ((h == 0) ? 1 : h) : 0;
    exp_d = (d == 0) ? 1 : d;
    if (mux) begin
      check_eq("R2", {name, " setup cycles"}, n_adv, s);
      check_eq("R3", {name, " hold cycles"}, n_pre - n_adv, exp_h);
    end else begin
      check_eq("R2", {name, " setup cycles"}, n_pre, s);
      check_eq("R7", {name, " adv stayed high"}, n_adv, 0);
    end
    check_eq("R4", {name, " data cycles"}, n_dat, exp_d);
    check_eq(wr ? "R6" : "R7", {name, " bus and strobe contents"}, bad_bus, 0);
    check_eq("R8", {name, " cs high at done"}, int'(cs_n), 1);
    if (!wr) check_eq("R5", {name, " read data"}, int'(rdata), int'(rbase + 16'(exp_d - 1)));
    @(negedge clk);
    check_eq("R5", {name, " done one cycle"}, int'(done), 0);
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        if (!cs_n || !we_n || !oe_n) stray++;
        @(negedge clk);
      end
      check_eq("R8", {name, " no access from busy request"}, stray, 0);
    end
  endtask

  task automatic t_reset();
    check_eq("R1", "cs_n", int'(cs_n), 1);
    check_eq("R1", "oe_n", int'(oe_n), 1);
    check_eq("R1", "we_n", int'(we_n), 1);
    check_eq("R1", "adv_n", int'(adv_n), 1);
    check_eq("R1", "ad_oe", int'(ad_oe), 0);
    check_eq("R1", "done", int'(done), 0);
    check_eq("R1", "ready", int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_access("mux read",             1'b0, 1'b1, 16'h1234, 16'h0,    3, 2, 4,   16'h5000, 1'b0, -1);
    run_access("plain write",          1'b1, 1'b0, 16'h00A5, 16'hBEEF, 1, 5, 3,   16'h0,    1'b0, -1);
    run_access("plain read zero codes",1'b0, 1'b0, 16'h0F0F, 16'h0,    0, 0, 0,   16'h7700, 1'b0, -1);
    run_access("mux write hold zero",  1'b1, 1'b1, 16'h4321, 16'hC0DE, 0, 0, 2,   16'h0,    1'b0, -1);
    run_access("mux read max",         1'b0, 1'b1, 16'hFFFE, 16'h0,    15, 15, 255, 16'h2000, 1'b0, -1);
    run_access("busy poke R9",         1'b0, 1'b1, 16'h0222, 16'h0,    2, 1, 6,   16'h3300, 1'b1, 5);
    run_access("after change",         1'b1, 1'b1, 16'h0333, 16'h9999, 5, 1, 1,   16'h0,    1'b0, -1);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule